// File: doc/BRIEF.md
# Synchronous Serial Receiver with Overrun Protection

The block receives 8-bit frames from a serial data line that is clocked by a serial clock supplied from outside. Both the clock and the data are brought into the system clock domain through a two-flop synchronizer. On each detected rising edge of the serial clock the block samples one bit. Bits arrive most significant first and are assembled in a shift register. When a frame is complete and the receive buffer is empty, the byte moves into the buffer, a buffer-full flag is set, and a one-cycle interrupt request is raised.

If a frame completes while the buffer still holds an unread byte, the block raises a receive-error flag. It then freezes both the buffer and the shift register, and ignores all later data for as long as the flag stays set. The host recovers both bytes with two reads. The first read returns the older byte and loads the frozen shift-register byte into the buffer. The second read returns that byte and clears both the error flag and the buffer-full flag.

The host uses one control write strobe, which carries a start bit and an abort (inhibit) bit. Clearing the start bit gives a graceful stop, which takes effect at the end of the current frame. Setting the abort bit stops the block at once and clears the start bit, the flags and the buffer. A control FSM has three states: IDLE, RECV and DRAIN. Its transitions are START (IDLE to RECV), STOP_REQ (RECV to DRAIN), DRAIN_DONE (DRAIN to IDLE at frame completion) and ABORT (any state to IDLE).

Top module: `srx_unit`

## Requirements
- R1: Data is sampled on each synchronized rising edge of `sclk_in` while the block is busy. Eight edges form one frame, and the first bit received becomes bit 7 of the byte.
- R2: A completed frame with `buf_full`=0 is written to the buffer. `buf_full` rises, `rd_data` shows the byte, and `irq` pulses high for exactly one cycle.
- R3: With `rx_err`=0, a one-cycle `buf_rd` pulse clears `buf_full`.
- R4: A frame that completes while `buf_full`=1 sets `rx_err`=1. `rd_data` keeps the earlier byte and `buf_full` stays 1.
- R5: While `rx_err`=1, further frames are ignored: `rd_data` is unchanged and `irq` does not pulse.
- R6: In error, the first `buf_rd` makes `rd_data` show the byte completed at the moment of the error, and `rx_err` stays 1. The second `buf_rd` clears both `rx_err` and `buf_full`.
- R7: A control write with `ctl_run`=0 and `ctl_abort`=0 in state RECV keeps reception going, with `busy`=1 and `start_bit`=0. At the next frame completion that frame is still delivered, and `busy` falls.
- R8: A control write with `ctl_abort`=1 forces `busy`, `start_bit`, `buf_full`, `rx_err` and `rd_data` to 0 on the next cycle. It also restarts the bit count, so the next frame starts at bit 7.
- R9: A control write with `ctl_run`=1 and `ctl_abort`=0 while `busy`=0 sets `busy` and `start_bit`. The same write while `busy`=1 is ignored.
- R10: Serial clock edges while `busy`=0 change neither the buffer nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | External serial clock, asynchronous |
| sdata_in | input | 1 | Serial data, MSB first |
| ctl_wr | input | 1 | One-cycle control write strobe |
| ctl_run | input | 1 | Start bit value written with `ctl_wr` |
| ctl_abort | input | 1 | Abort bit value written with `ctl_wr` |
| buf_rd | input | 1 | One-cycle receive buffer read strobe |
| rd_data | output | 8 | Receive buffer contents |
| start_bit | output | 1 | Start bit as held by the block |
| busy | output | 1 | Reception active (RECV or DRAIN) |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| rx_err | output | 1 | Overrun error |
| irq | output | 1 | One-cycle pulse on a buffer load from the shift register |

## Verification
The assertions check the following on every cycle:
- the error flag never appears without the buffer-full flag;
- the interrupt is a single-cycle pulse that coincides with the buffer-full flag rising;
- the buffer stays frozen during an error unless a read or abort occurs;
- an abort clears the outputs on the next cycle;
- busy cannot rise without a start write.

Only the bench scenarios can show the following:
- the assembled byte values and bit order;
- the order of the double read after an overrun;
- that a graceful stop still delivers the frame in flight;
- that the frame count restarts after an abort.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_DRAIN = 2'd2
    } srx_state_e;
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_async,
    input  logic sdata_async,
    output logic sclk_rise,
    output logic sdata_sync
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_pipe <= '0;
                    dat_pipe <= '0;
                end else begin
                    clk_pipe <= sclk_async;
                    dat_pipe <= sdata_async;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_pipe <= '0;
                    dat_pipe <= '0;
                end else begin
                    clk_pipe <= {clk_pipe[STAGES-2:0], sclk_async};
                    dat_pipe <= {dat_pipe[STAGES-2:0], sdata_async};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_pipe[STAGES-1];
    end

    assign sclk_rise  = clk_pipe[STAGES-1] & ~clk_prev;
    assign sdata_sync = dat_pipe[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         active,
    input  logic         hold,
    input  logic         rise,
    input  logic         din,
    output logic         frame_done,
    output logic [W-1:0] byte_nxt,
    output logic [W-1:0] shreg
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;

    assign byte_nxt   = {shreg[W-2:0], din};
    assign frame_done = active && rise && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            shreg <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            shreg <= '0;
        end else if (active && rise) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (!hold) shreg <= byte_nxt;
        end
    end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic         ctl_run,
    input  logic         ctl_abort,
    input  logic         buf_rd,
    input  logic         frame_done,
    input  logic [W-1:0] byte_nxt,
    input  logic [W-1:0] shreg,
    output logic         sh_clr,
    output logic         sh_active,
    output logic         sh_hold,
    output logic [W-1:0] buf_q,
    output logic         start_bit,
    output logic         busy,
    output logic         full_q,
    output logic         err_q,
    output logic         irq_q
);
    srx_state_e state_q, state_d;
    logic       rd_phase_q;
    logic       abort_req, start_req, stop_req;

    assign abort_req = ctl_wr && ctl_abort;
    assign start_req = ctl_wr && ctl_run && !ctl_abort;
    assign stop_req  = ctl_wr && !ctl_run && !ctl_abort;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req)  state_d = ST_RECV;
            ST_RECV:  if (stop_req)   state_d = ST_DRAIN;
            ST_DRAIN: if (frame_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
        if (abort_req) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start_bit = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin start_bit = 1'b0; busy = 1'b0; end
            ST_RECV:  begin start_bit = 1'b1; busy = 1'b1; end
            ST_DRAIN: begin start_bit = 1'b0; busy = 1'b1; end
            default:  begin start_bit = 1'b0; busy = 1'b0; end
        endcase
    end

    assign sh_active = busy && !abort_req;
    assign sh_hold   = err_q;
    assign sh_clr    = abort_req || (state_q == ST_IDLE && start_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q      <= '0;
            full_q     <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
            rd_phase_q <= 1'b0;
        end else if (abort_req) begin
            buf_q      <= '0;
            full_q     <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
            rd_phase_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (err_q) begin
                if (buf_rd && !rd_phase_q) begin
                    buf_q      <= shreg;
                    rd_phase_q <= 1'b1;
                end else if (buf_rd) begin
                    err_q      <= 1'b0;
                    full_q     <= 1'b0;
                    rd_phase_q <= 1'b0;
                end
            end else if (frame_done && full_q && !buf_rd) begin
                err_q <= 1'b1;
            end else if (frame_done) begin
                buf_q  <= byte_nxt;
                full_q <= 1'b1;
                irq_q  <= 1'b1;
            end else if (buf_rd) begin
                full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/srx_unit.sv
module srx_unit #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_in,
    input  logic         sdata_in,
    input  logic         ctl_wr,
    input  logic         ctl_run,
    input  logic         ctl_abort,
    input  logic         buf_rd,
    output logic [W-1:0] rd_data,
    output logic         start_bit,
    output logic         busy,
    output logic         buf_full,
    output logic         rx_err,
    output logic         irq
);
    logic         rise, din;
    logic         frame_done, sh_clr, sh_active, sh_hold;
    logic [W-1:0] byte_nxt, shreg;

    srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_async (sclk_in),
        .sdata_async(sdata_in),
        .sclk_rise  (rise),
        .sdata_sync (din)
    );

    srx_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sh_clr),
        .active    (sh_active),
        .hold      (sh_hold),
        .rise      (rise),
        .din       (din),
        .frame_done(frame_done),
        .byte_nxt  (byte_nxt),
        .shreg     (shreg)
    );

    srx_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_run   (ctl_run),
        .ctl_abort (ctl_abort),
        .buf_rd    (buf_rd),
        .frame_done(frame_done),
        .byte_nxt  (byte_nxt),
        .shreg     (shreg),
        .sh_clr    (sh_clr),
        .sh_active (sh_active),
        .sh_hold   (sh_hold),
        .buf_q     (rd_data),
        .start_bit (start_bit),
        .busy      (busy),
        .full_q    (buf_full),
        .err_q     (rx_err),
        .irq_q     (irq)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctl_wr,
    input logic         ctl_run,
    input logic         ctl_abort,
    input logic         buf_rd,
    input logic [W-1:0] rd_data,
    input logic         busy,
    input logic         buf_full,
    input logic         rx_err,
    input logic         irq
);
    // R4
    err_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> buf_full);

    // R2
    irq_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $rose(buf_full));

    // R2
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !buf_rd && !(ctl_wr && ctl_abort)) |=> ($stable(rd_data) && !irq));

    // R8
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_abort) |=> (!busy && !buf_full && !rx_err && rd_data == '0));

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(ctl_wr && ctl_run && !ctl_abort)) |=> !busy);
endmodule

bind srx_unit srx_checker #(.W(W)) u_srx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_run  (ctl_run),
    .ctl_abort(ctl_abort),
    .buf_rd   (buf_rd),
    .rd_data  (rd_data),
    .busy     (busy),
    .buf_full (buf_full),
    .rx_err   (rx_err),
    .irq      (irq)
);

// File: tb/test_srx_unit.sv
module test_srx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b0, sdata_in = 1'b0;
    logic       ctl_wr = 1'b0, ctl_run = 1'b0, ctl_abort = 1'b0, buf_rd = 1'b0;
    logic [7:0] rd_data;
    logic       start_bit, busy, buf_full, rx_err, irq;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    srx_unit i_srx_unit (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_abort(ctl_abort), .buf_rd(buf_rd),
        .rd_data(rd_data), .start_bit(start_bit), .busy(busy),
        .buf_full(buf_full), .rx_err(rx_err), .irq(irq)
    );

    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    function automatic logic [7:0] rand_byte();
        return 8'($urandom_range(0, 255));
    endfunction

    // expected rd_data after k reads in an overrun: older byte first, then held byte
    function automatic logic [7:0] exp_err_read(int k, logic [7:0] older, logic [7:0] held);
        return (k == 0) ? older : held;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        sdata_in = b;
        sclk_in  = 1'b0;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    task automatic send_bits(logic [7:0] v, int hi, int lo);
        for (int i = hi; i >= lo; i--) send_bit(v[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic ctl(logic run, logic abort);
        ctl_wr = 1'b1; ctl_run = run; ctl_abort = abort;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_run = 1'b0; ctl_abort = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] v);
        v = rd_data;
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b, c, v;
        int irq0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset flags", {buf_full, rx_err, irq, start_bit}, 0);
        chk("R8 reset data", rd_data, 0);

        // R10: idle edges ignored
        send_bits(8'hA5, 7, 0);
        chk("R10 idle full", buf_full, 0);
        chk("R10 idle data", rd_data, 0);

        // R9 start
        ctl(1'b1, 1'b0);
        chk("R9 busy after start", {busy, start_bit}, 2'b11);

        // R1 R2 R3 random frames
        for (int n = 0; n < 6; n++) begin
            a = (n == 0) ? 8'h80 : (n == 1) ? 8'h01 : rand_byte();
            irq0 = irq_cnt;
            send_bits(a, 7, 0);
            chk("R1 byte", rd_data, a);
            chk("R2 full", buf_full, 1);
            chk("R2 irq once", irq_cnt - irq0, 1);
            do_read(v);
            chk("R3 full cleared", buf_full, 0);
        end

        // R4 R5 R6 overrun
        a = rand_byte(); b = rand_byte(); c = ~b;
        send_bits(a, 7, 0);
        irq0 = irq_cnt;
        send_bits(b, 7, 0);
        chk("R4 err set", {rx_err, buf_full}, 2'b11);
        chk("R4 buffer kept", rd_data, a);
        send_bits(c, 7, 0);
        chk("R5 ignored data", rd_data, a);
        chk("R5 no irq", irq_cnt - irq0, 0);
        do_read(v);
        chk("R6 first read", v, exp_err_read(0, a, b));
        chk("R6 err held", rx_err, 1);
        chk("R6 held byte shown", rd_data, exp_err_read(1, a, b));
        do_read(v);
        chk("R6 second read", v, exp_err_read(1, a, b));
        chk("R6 flags cleared", {rx_err, buf_full}, 2'b00);

        // R7 graceful stop, R9 start ignored while busy
        a = rand_byte();
        send_bits(a, 7, 5);
        ctl(1'b0, 1'b0);
        chk("R7 still busy", {busy, start_bit}, 2'b10);
        ctl(1'b1, 1'b0);
        chk("R9 start ignored", start_bit, 0);
        send_bits(a, 4, 0);
        chk("R7 stopped", busy, 0);
        chk("R7 frame delivered", {buf_full, rd_data}, {1'b1, a});
        do_read(v);

        // R8 abort mid-frame with buffered byte and error
        ctl(1'b1, 1'b0);
        send_bits(8'h3C, 7, 0);
        send_bits(8'hC3, 7, 0);
        send_bits(8'hFF, 7, 5);
        ctl_wr = 1'b1; ctl_abort = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_abort = 1'b0;
        chk("R8 abort busy", {busy, start_bit}, 0);
        chk("R8 abort flags", {buf_full, rx_err}, 0);
        chk("R8 abort data", rd_data, 0);
        ctl(1'b1, 1'b0);
        a = rand_byte();
        send_bits(a, 7, 0);
        chk("R8 count restarted", rd_data, a);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule